// File: doc/BRIEF.md
# Clock Configuration Register Bank with Two-Wire Serial Slave

This block holds the frequency settings of a multi-channel clock generator. A host writes them over the two-wire serial bus (I2C), using standard or fast mode rates. The slave answers one fixed 7-bit address, and a strap input picks which of two values that address is. After the address the host sends one command byte that names the target register. Data bytes follow, least significant byte first. Each byte is collected in a staging word, and the whole word is copied into the register only when the bus STOP condition arrives.

There are two register shapes. One narrow 32-bit word drives the plain PLL channel. Several 48-bit words drive the spread-spectrum channels. Each word is split into divider, loop and output-pad fields, and every field appears on its own output port. The top bits of each word are reserved and always hold zero. A host can read any register back: it writes the command byte, sends a repeated START with the read flag set, and then clocks bytes out until it answers NACK.

SCL and SDA are sampled by a system clock that runs at least eight times faster than SCL. The block drives SDA as an open-drain enable.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: With `addr_sel` low the slave acknowledges only address 7'b1001111, and with it high only 7'b1011111. Every other address, including the all-zero general call, gets NACK (SDA left high).
- R2: A write is START, address with R/W=0, a command byte, then data bytes. Each byte is acknowledged by pulling SDA low during the ninth clock. Data bytes fill the register starting from bits [7:0].
- R3: Command 0 selects the 4-byte narrow register. Commands 1 to NSS select wide registers 0 to NSS-1, each 6 bytes. Any larger command gets NACK and changes nothing.
- R4: A register changes only at STOP, and only if exactly its byte count was received. A shorter write leaves it unchanged. Data bytes past the byte count get NACK, and the full register is still committed.
- R5: Bits 47:46 of a wide register and bits 31:28 of the narrow register ignore written data and always read as 0.
- R6: After a repeated START with R/W=1, the slave returns the selected register starting from byte 0, one byte per master ACK. Byte positions past the register's length read 0x00. A master NACK ends the transfer.
- R7: Wide register fields are: M [11:0], N [22:12], K [27:23], modulation-rate code [30:28], pump current [34:31], oscillator gain [40:35], depth code [43:41], drive [44], slew [45]. Narrow register fields are: M [5:0], N [10:6], K [15:11], pump current [19:16], oscillator gain [25:20], drive [26], slew [27]. Each field drives its own output port.
- R8: The slave changes its SDA drive only while SCL is low. It releases SDA at the SCL fall that ends each acknowledge bit.
- R9: After reset all registers are zero and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel | input | 1 | Strap choosing between the two slave addresses |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low |
| pll_mdiv_o | output | 6 | Narrow register M field |
| pll_ndiv_o | output | 5 | Narrow register N field |
| pll_kdiv_o | output | 5 | Narrow register K field |
| pll_pump_o | output | 4 | Narrow register pump current |
| pll_gain_o | output | 6 | Narrow register oscillator gain |
| pll_drive_o | output | 1 | Narrow register drive strength |
| pll_slew_o | output | 1 | Narrow register slew select |
| ss_mdiv_o | output | NSS x 12 | Wide register M fields |
| ss_ndiv_o | output | NSS x 11 | Wide register N fields |
| ss_kdiv_o | output | NSS x 5 | Wide register K fields |
| ss_rate_o | output | NSS x 3 | Wide register modulation-rate codes |
| ss_pump_o | output | NSS x 4 | Wide register pump currents |
| ss_gain_o | output | NSS x 6 | Wide register oscillator gains |
| ss_depth_o | output | NSS x 3 | Wide register depth codes |
| ss_drive_o | output | NSS | Wide register drive strengths |
| ss_slew_o | output | NSS | Wide register slew selects |

## Verification
The hardest case to reach is a read that follows a repeated START. The slave must keep the command-selected register through the second address phase and must not commit anything, even though a write was in progress. The bench writes a command byte, issues a fresh START with the read flag set, and clocks one byte past the register's length so the zero fill is visible. It also covers two other awkward cases: a write that ends early, and a write with one byte too many. Both are checked through the field outputs after STOP.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    localparam int WIDE_W       = 48;
    localparam int NARROW_W     = 32;
    localparam int WIDE_BYTES   = WIDE_W / 8;
    localparam int NARROW_BYTES = NARROW_W / 8;

    // bits that accept writes; the rest stay zero
    localparam logic [WIDE_W-1:0]   WIDE_KEEP   = 48'h3FFF_FFFF_FFFF;
    localparam logic [NARROW_W-1:0] NARROW_KEEP = 32'h0FFF_FFFF;

    localparam logic [6:0] SLAVE_ADDR_A = 7'b1001111;
    localparam logic [6:0] SLAVE_ADDR_B = 7'b1011111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } bus_st_e;

    typedef enum logic [1:0] {
        K_ADDR,
        K_CMD,
        K_DATA
    } byte_kind_e;

    function automatic logic [2:0] reg_bytes(input int unsigned sel);
        return (sel == 0) ? 3'(NARROW_BYTES) : 3'(WIDE_BYTES);
    endfunction

endpackage

// File: rtl/clkcfg_sync.sv
module clkcfg_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    // [0] first flop, [1] synchronised, [2] previous synchronised
    typedef struct packed {
        logic [2:0] scl;
        logic [2:0] sda;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d.scl = {sy_q.scl[1:0], scl_i};
        sy_d.sda = {sy_q.sda[1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '1;
        else        sy_q <= sy_d;
    end

    assign sda_o      = sy_q.sda[1];
    assign scl_rise_o = sy_q.scl[1] & ~sy_q.scl[2];
    assign scl_fall_o = ~sy_q.scl[1] & sy_q.scl[2];
    assign start_o    = sy_q.scl[1] & sy_q.scl[2] & ~sy_q.sda[1] & sy_q.sda[2];
    assign stop_o     = sy_q.scl[1] & sy_q.scl[2] & sy_q.sda[1] & ~sy_q.sda[2];

endmodule

// File: rtl/clkcfg_engine.sv
module clkcfg_engine
    import clkcfg_pkg::*;
#(
    parameter int NSS   = 4,
    parameter int SEL_W = $clog2(NSS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_sel_i,
    input  logic             sda_i,
    input  logic             scl_rise_i,
    input  logic             scl_fall_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [7:0]       rd_byte_i,
    output logic             sda_oe_o,
    output logic [SEL_W-1:0] sel_o,
    output logic [2:0]       rd_idx_o,
    output logic             stg_we_o,
    output logic [2:0]       stg_idx_o,
    output logic [7:0]       stg_byte_o,
    output logic             commit_o
);
    typedef struct packed {
        bus_st_e          st;
        byte_kind_e       kind;
        logic [3:0]       cnt;
        logic [7:0]       sh;
        logic [SEL_W-1:0] sel;
        logic [2:0]       wr_idx;
        logic [2:0]       rd_idx;
        logic             wr_act;
        logic             tx_next;
        logic             mack;
        logic             sda_oe;
    } eng_t;

    eng_t en_d, en_q;
    logic [6:0] my_addr;
    logic [2:0] sel_len;

    assign my_addr = addr_sel_i ? SLAVE_ADDR_B : SLAVE_ADDR_A;
    assign sel_len = reg_bytes(int'(en_q.sel));

    always_comb begin
        en_d       = en_q;
        stg_we_o   = 1'b0;
        stg_idx_o  = en_q.wr_idx;
        stg_byte_o = en_q.sh;
        commit_o   = 1'b0;
        if (stop_i) begin
            commit_o    = en_q.wr_act && (en_q.wr_idx == sel_len);
            en_d.st     = ST_IDLE;
            en_d.sda_oe = 1'b0;
            en_d.wr_act = 1'b0;
        end else if (start_i) begin
            en_d.st     = ST_RX;
            en_d.kind   = K_ADDR;
            en_d.cnt    = '0;
            en_d.sda_oe = 1'b0;
            en_d.wr_act = 1'b0;
        end else begin
            unique case (en_q.st)
                ST_RX: begin
                    if (scl_rise_i) begin
                        en_d.sh  = {en_q.sh[6:0], sda_i};
                        en_d.cnt = en_q.cnt + 4'd1;
                    end else if (scl_fall_i && en_q.cnt == 4'd8) begin
                        unique case (en_q.kind)
                            K_ADDR: begin
                                if (en_q.sh[7:1] == my_addr) begin
                                    en_d.st      = ST_ACK;
                                    en_d.sda_oe  = 1'b1;
                                    en_d.rd_idx  = '0;
                                    en_d.tx_next = en_q.sh[0];
                                    en_d.kind    = K_CMD;
                                end else begin
                                    en_d.st = ST_IDLE;
                                end
                            end
                            K_CMD: begin
                                if (int'(en_q.sh) <= NSS) begin
                                    en_d.st      = ST_ACK;
                                    en_d.sda_oe  = 1'b1;
                                    en_d.sel     = en_q.sh[SEL_W-1:0];
                                    en_d.wr_idx  = '0;
                                    en_d.wr_act  = 1'b1;
                                    en_d.tx_next = 1'b0;
                                    en_d.kind    = K_DATA;
                                end else begin
                                    en_d.st = ST_IDLE;
                                end
                            end
                            default: begin
                                if (en_q.wr_idx < sel_len) begin
                                    en_d.st     = ST_ACK;
                                    en_d.sda_oe = 1'b1;
                                    stg_we_o    = 1'b1;
                                    en_d.wr_idx = en_q.wr_idx + 3'd1;
                                end else begin
                                    en_d.st = ST_IDLE;
                                end
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall_i) begin
                        en_d.cnt = '0;
                        if (en_q.tx_next) begin
                            en_d.st     = ST_TX;
                            en_d.sh     = rd_byte_i;
                            en_d.sda_oe = ~rd_byte_i[7];
                        end else begin
                            en_d.st     = ST_RX;
                            en_d.sda_oe = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall_i) begin
                        if (en_q.cnt == 4'd7) begin
                            en_d.st     = ST_MACK;
                            en_d.sda_oe = 1'b0;
                            en_d.mack   = 1'b0;
                        end else begin
                            en_d.sh     = {en_q.sh[6:0], 1'b0};
                            en_d.sda_oe = ~en_q.sh[6];
                            en_d.cnt    = en_q.cnt + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise_i) begin
                        en_d.mack = ~sda_i;
                        if (!sda_i && en_q.rd_idx != 3'd7) begin
                            en_d.rd_idx = en_q.rd_idx + 3'd1;
                        end
                    end else if (scl_fall_i) begin
                        en_d.cnt = '0;
                        if (en_q.mack) begin
                            en_d.st     = ST_TX;
                            en_d.sh     = rd_byte_i;
                            en_d.sda_oe = ~rd_byte_i[7];
                        end else begin
                            en_d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= '0;
            en_q.st   <= ST_IDLE;
            en_q.kind <= K_ADDR;
        end else begin
            en_q <= en_d;
        end
    end

    assign sda_oe_o = en_q.sda_oe;
    assign sel_o    = en_q.sel;
    assign rd_idx_o = en_q.rd_idx;

    // R8
    sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> $past(scl_fall_i || start_i || stop_i));

    // R8
    sda_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe_o |-> (en_q.st == ST_ACK || en_q.st == ST_TX));

    // R2
    stage_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stg_we_o |-> en_q.wr_act);

    // R4
    commit_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> stop_i);

endmodule

// File: rtl/clkcfg_regfile.sv
module clkcfg_regfile
    import clkcfg_pkg::*;
#(
    parameter int NSS   = 4,
    parameter int SEL_W = $clog2(NSS + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          stg_we_i,
    input  logic [2:0]                    stg_idx_i,
    input  logic [7:0]                    stg_byte_i,
    input  logic                          commit_i,
    input  logic [SEL_W-1:0]              sel_i,
    input  logic [2:0]                    rd_idx_i,
    output logic [7:0]                    rd_byte_o,
    output logic [NARROW_W-5:0]           pll_o,
    output logic [NSS-1:0][WIDE_W-3:0]    ss_o
);
    typedef struct packed {
        logic [WIDE_W-1:0]            stage;
        logic [NARROW_W-1:0]          pll;
        logic [NSS-1:0][WIDE_W-1:0]   ss;
    } bank_t;

    bank_t bk_d, bk_q;
    logic [WIDE_W-1:0] rd_word;

    always_comb begin
        bk_d = bk_q;
        if (stg_we_i) begin
            for (int b = 0; b < WIDE_BYTES; b++) begin
                if (stg_idx_i == 3'(b)) bk_d.stage[b*8 +: 8] = stg_byte_i;
            end
        end
        if (commit_i) begin
            if (sel_i == '0) bk_d.pll = bk_q.stage[NARROW_W-1:0] & NARROW_KEEP;
            for (int c = 0; c < NSS; c++) begin
                if (int'(sel_i) == c + 1) bk_d.ss[c] = bk_q.stage & WIDE_KEEP;
            end
        end
    end

    always_comb begin
        rd_word = {{(WIDE_W-NARROW_W){1'b0}}, bk_q.pll};
        for (int c = 0; c < NSS; c++) begin
            if (int'(sel_i) == c + 1) rd_word = bk_q.ss[c];
        end
        rd_byte_o = '0;
        for (int b = 0; b < WIDE_BYTES; b++) begin
            if (rd_idx_i == 3'(b)) rd_byte_o = rd_word[b*8 +: 8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign pll_o = bk_q.pll[NARROW_W-5:0];

    generate
        for (genvar g = 0; g < NSS; g++) begin : g_ss
            assign ss_o[g] = bk_q.ss[g][WIDE_W-3:0];

            // R4
            ss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !commit_i |=> $stable(bk_q.ss[g]));

            // R5
            ss_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
                bk_q.ss[g][WIDE_W-1:WIDE_W-2] == 2'b00);
        end
    endgenerate

    // R4
    pll_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(bk_q.pll));

    // R5
    pll_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bk_q.pll[NARROW_W-1:NARROW_W-4] == 4'h0);

endmodule

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave
    import clkcfg_pkg::*;
#(
    parameter int NSS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  addr_sel,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [5:0]            pll_mdiv_o,
    output logic [4:0]            pll_ndiv_o,
    output logic [4:0]            pll_kdiv_o,
    output logic [3:0]            pll_pump_o,
    output logic [5:0]            pll_gain_o,
    output logic                  pll_drive_o,
    output logic                  pll_slew_o,
    output logic [NSS-1:0][11:0]  ss_mdiv_o,
    output logic [NSS-1:0][10:0]  ss_ndiv_o,
    output logic [NSS-1:0][4:0]   ss_kdiv_o,
    output logic [NSS-1:0][2:0]   ss_rate_o,
    output logic [NSS-1:0][3:0]   ss_pump_o,
    output logic [NSS-1:0][5:0]   ss_gain_o,
    output logic [NSS-1:0][2:0]   ss_depth_o,
    output logic [NSS-1:0]        ss_drive_o,
    output logic [NSS-1:0]        ss_slew_o
);
    localparam int SEL_W = $clog2(NSS + 1);

    logic sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic [7:0] rd_byte;
    logic [SEL_W-1:0] sel;
    logic [2:0] rd_idx, stg_idx;
    logic stg_we, commit;
    logic [7:0] stg_byte;
    logic [NARROW_W-5:0] pll_word;
    logic [NSS-1:0][WIDE_W-3:0] ss_word;

    clkcfg_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (bus_start),
        .stop_o     (bus_stop)
    );

    clkcfg_engine #(.NSS(NSS), .SEL_W(SEL_W)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_sel_i (addr_sel),
        .sda_i      (sda_s),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (bus_start),
        .stop_i     (bus_stop),
        .rd_byte_i  (rd_byte),
        .sda_oe_o   (sda_oe),
        .sel_o      (sel),
        .rd_idx_o   (rd_idx),
        .stg_we_o   (stg_we),
        .stg_idx_o  (stg_idx),
        .stg_byte_o (stg_byte),
        .commit_o   (commit)
    );

    clkcfg_regfile #(.NSS(NSS), .SEL_W(SEL_W)) u_regfile (
        .clk        (clk),
        .rst_n      (rst_n),
        .stg_we_i   (stg_we),
        .stg_idx_i  (stg_idx),
        .stg_byte_i (stg_byte),
        .commit_i   (commit),
        .sel_i      (sel),
        .rd_idx_i   (rd_idx),
        .rd_byte_o  (rd_byte),
        .pll_o      (pll_word),
        .ss_o       (ss_word)
    );

    // R7 narrow field split
    assign pll_mdiv_o  = pll_word[5:0];
    assign pll_ndiv_o  = pll_word[10:6];
    assign pll_kdiv_o  = pll_word[15:11];
    assign pll_pump_o  = pll_word[19:16];
    assign pll_gain_o  = pll_word[25:20];
    assign pll_drive_o = pll_word[26];
    assign pll_slew_o  = pll_word[27];

    generate
        for (genvar g = 0; g < NSS; g++) begin : g_fields
            assign ss_mdiv_o[g]  = ss_word[g][11:0];
            assign ss_ndiv_o[g]  = ss_word[g][22:12];
            assign ss_kdiv_o[g]  = ss_word[g][27:23];
            assign ss_rate_o[g]  = ss_word[g][30:28];
            assign ss_pump_o[g]  = ss_word[g][34:31];
            assign ss_gain_o[g]  = ss_word[g][40:35];
            assign ss_depth_o[g] = ss_word[g][43:41];
            assign ss_drive_o[g] = ss_word[g][44];
            assign ss_slew_o[g]  = ss_word[g][45];
        end
    endgenerate

endmodule

// File: tb/clkcfg_i2c_slave_bench.sv
module clkcfg_i2c_slave_bench;
    localparam int NSS = 4;
    localparam int Q   = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strap = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_oe;
    logic [5:0] pll_mdiv; logic [4:0] pll_ndiv; logic [4:0] pll_kdiv;
    logic [3:0] pll_pump; logic [5:0] pll_gain; logic pll_drive; logic pll_slew;
    logic [NSS-1:0][11:0] ss_mdiv; logic [NSS-1:0][10:0] ss_ndiv;
    logic [NSS-1:0][4:0] ss_kdiv; logic [NSS-1:0][2:0] ss_rate;
    logic [NSS-1:0][3:0] ss_pump; logic [NSS-1:0][5:0] ss_gain;
    logic [NSS-1:0][2:0] ss_depth; logic [NSS-1:0] ss_drive; logic [NSS-1:0] ss_slew;

    assign sda_line = sda_m & ~sda_oe;

    always #2 clk = ~clk;

    clkcfg_i2c_slave #(.NSS(NSS)) u_clkcfg_i2c_slave (
        .clk(clk), .rst_n(rst_n), .addr_sel(strap), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe),
        .pll_mdiv_o(pll_mdiv), .pll_ndiv_o(pll_ndiv), .pll_kdiv_o(pll_kdiv),
        .pll_pump_o(pll_pump), .pll_gain_o(pll_gain), .pll_drive_o(pll_drive),
        .pll_slew_o(pll_slew),
        .ss_mdiv_o(ss_mdiv), .ss_ndiv_o(ss_ndiv), .ss_kdiv_o(ss_kdiv),
        .ss_rate_o(ss_rate), .ss_pump_o(ss_pump), .ss_gain_o(ss_gain),
        .ss_depth_o(ss_depth), .ss_drive_o(ss_drive), .ss_slew_o(ss_slew)
    );

    typedef struct {
        logic [7:0] val;
        string      req;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] obs_q[$];
    exp_t       e_item;
    logic [7:0] o_item;
    int checks = 0;
    int errors = 0;
    int r8_bad = 0;
    logic oe_prev = 1'b0;
    logic scl_prev = 1'b1;

    task automatic chk(input logic [47:0] act, input logic [47:0] exp,
                       input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: pops expected items as bus results appear
    initial begin
        forever begin
            @(negedge clk);
            while (obs_q.size() > 0) begin
                o_item = obs_q.pop_front();
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL scoreboard: actual %0h expected none", o_item);
                end else begin
                    e_item = exp_q.pop_front();
                    chk({40'b0, o_item}, {40'b0, e_item.val}, e_item.req, "bus item");
                end
            end
        end
    end

    // R8: slave drive must not change across a high SCL phase
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== oe_prev) && scl_m && scl_prev) r8_bad++;
        oe_prev  <= sda_oe;
        scl_prev <= scl_m;
    end

    task automatic qdel();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qdel();
        scl_m = 1'b1; qdel();
        sda_m = 1'b0; qdel();
        scl_m = 1'b0; qdel();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qdel();
        scl_m = 1'b1; qdel();
        sda_m = 1'b1; qdel();
        qdel();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; qdel();
        scl_m = 1'b1; qdel(); qdel();
        scl_m = 1'b0; qdel();
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; qdel();
        scl_m = 1'b1; qdel();
        b = sda_line; qdel();
        scl_m = 1'b0; qdel();
    endtask

    // exp_nack: 0 = slave should pull SDA low
    task automatic send_byte(input logic [7:0] v, input logic exp_nack, input string req);
        logic a;
        exp_q.push_back('{val: {7'b0, exp_nack}, req: req});
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(a);
        obs_q.push_back({7'b0, a});
    endtask

    task automatic recv_byte(input logic [7:0] exp, input logic m_nack, input string req);
        logic [7:0] v;
        logic b;
        exp_q.push_back('{val: exp, req: req});
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        obs_q.push_back(v);
        send_bit(m_nack);
    endtask

    task automatic write_reg(input logic [6:0] a, input logic [7:0] cmd, input int n,
                             input logic [47:0] w, input string req);
        bus_start();
        send_byte({a, 1'b0}, 1'b0, req);
        send_byte(cmd, 1'b0, req);
        for (int i = 0; i < n; i++) send_byte(w[i*8 +: 8], 1'b0, req);
        bus_stop();
    endtask

    task automatic chk_pll(input logic [31:0] w, input string req);
        logic [31:0] k;
        k = w & 32'h0FFF_FFFF;
        chk({42'b0, pll_mdiv}, {42'b0, k[5:0]}, req, "pll M");
        chk({43'b0, pll_ndiv}, {43'b0, k[10:6]}, req, "pll N");
        chk({43'b0, pll_kdiv}, {43'b0, k[15:11]}, req, "pll K");
        chk({44'b0, pll_pump}, {44'b0, k[19:16]}, req, "pll pump");
        chk({42'b0, pll_gain}, {42'b0, k[25:20]}, req, "pll gain");
        chk({46'b0, pll_drive, pll_slew}, {46'b0, k[26], k[27]}, req, "pll drive/slew");
    endtask

    task automatic chk_ss(input int ch, input logic [47:0] w, input string req);
        logic [47:0] k;
        k = w & 48'h3FFF_FFFF_FFFF;
        chk({36'b0, ss_mdiv[ch]}, {36'b0, k[11:0]}, req, "ss M");
        chk({37'b0, ss_ndiv[ch]}, {37'b0, k[22:12]}, req, "ss N");
        chk({43'b0, ss_kdiv[ch]}, {43'b0, k[27:23]}, req, "ss K");
        chk({45'b0, ss_rate[ch]}, {45'b0, k[30:28]}, req, "ss rate");
        chk({44'b0, ss_pump[ch]}, {44'b0, k[34:31]}, req, "ss pump");
        chk({42'b0, ss_gain[ch]}, {42'b0, k[40:35]}, req, "ss gain");
        chk({45'b0, ss_depth[ch]}, {45'b0, k[43:41]}, req, "ss depth");
        chk({46'b0, ss_drive[ch], ss_slew[ch]}, {46'b0, k[44], k[45]}, req, "ss drive/slew");
    endtask

    task automatic finish_run();
        repeat (10) @(negedge clk);
        chk(48'(exp_q.size()), 48'd0, "R2", "unconsumed expected items");
        chk(48'(r8_bad), 48'd0, "R8", "SDA drive changes while SCL high");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    localparam logic [31:0] W_PLL  = 32'hF5A3_C6D9;
    localparam logic [47:0] W_SS1  = 48'hFFC3_8E5A_71B6;
    localparam logic [47:0] W_SS0  = 48'hC1E2_D3B4_A596;
    localparam logic [47:0] W_SS3  = 48'h7B6A_5948_3726;

    initial begin
        repeat (5) @(negedge clk);
        // R9 reset state
        chk({47'b0, sda_oe}, 48'd0, "R9", "sda_oe after reset");
        chk_pll(32'd0, "R9");
        for (int c = 0; c < NSS; c++) chk_ss(c, 48'd0, "R9");
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R2 R3 R7: narrow register write, command 0
        write_reg(7'b1001111, 8'd0, 4, {16'b0, W_PLL}, "R2");
        chk_pll(W_PLL, "R7");

        // R5 R7: wide register via command 2, reserved bits dropped
        write_reg(7'b1001111, 8'd2, 6, W_SS1, "R5");
        chk_ss(1, W_SS1, "R5");

        // R4: short write leaves register 2 unchanged
        write_reg(7'b1001111, 8'd3, 3, W_SS3, "R4");
        chk_ss(2, 48'd0, "R4");

        // R4: one byte too many is NACKed, register still committed
        bus_start();
        send_byte({7'b1001111, 1'b0}, 1'b0, "R4");
        send_byte(8'd1, 1'b0, "R4");
        for (int i = 0; i < 6; i++) send_byte(W_SS0[i*8 +: 8], 1'b0, "R4");
        send_byte(8'hEE, 1'b1, "R4");
        bus_stop();
        chk_ss(0, W_SS0, "R4");

        // R3: out-of-range command is NACKed, nothing changes
        bus_start();
        send_byte({7'b1001111, 1'b0}, 1'b0, "R3");
        send_byte(8'd5, 1'b1, "R3");
        bus_stop();
        chk_pll(W_PLL, "R3");
        chk_ss(0, W_SS0, "R3");

        // R1: other addresses and general call ignored
        bus_start();
        send_byte({7'b1011111, 1'b0}, 1'b1, "R1");
        bus_stop();
        bus_start();
        send_byte(8'h00, 1'b1, "R1");
        bus_stop();

        // R6: read back register 2 after repeated start, one byte past end
        bus_start();
        send_byte({7'b1001111, 1'b0}, 1'b0, "R6");
        send_byte(8'd2, 1'b0, "R6");
        bus_start();
        send_byte({7'b1001111, 1'b1}, 1'b0, "R6");
        for (int i = 0; i < 6; i++)
            recv_byte((W_SS1 & 48'h3FFF_FFFF_FFFF) >> (i*8), 1'b0, "R6");
        recv_byte(8'h00, 1'b1, "R6");
        bus_stop();
        chk_ss(1, W_SS1, "R6");

        // R5 R6: narrow register readback, reserved nibble reads 0
        bus_start();
        send_byte({7'b1001111, 1'b0}, 1'b0, "R5");
        send_byte(8'd0, 1'b0, "R5");
        bus_start();
        send_byte({7'b1001111, 1'b1}, 1'b0, "R5");
        for (int i = 0; i < 4; i++)
            recv_byte((W_PLL & 32'h0FFF_FFFF) >> (i*8), (i == 3), "R5");
        bus_stop();

        // R1: strap high switches the address
        strap = 1'b1;
        repeat (5) @(negedge clk);
        bus_start();
        send_byte({7'b1001111, 1'b0}, 1'b1, "R1");
        bus_stop();
        write_reg(7'b1011111, 8'd4, 6, W_SS3, "R1");
        chk_ss(3, W_SS3, "R1");

        finish_run();
    end

endmodule